// File: doc/BRIEF.md
# Magic packet detector

This block watches the received bytes of Ethernet frames for a wake-up pattern: the station's 48-bit physical address repeated sixteen times back to back, 96 bytes in all. The pattern may start at any offset of the data field. Scanning starts only after the 14-byte header (destination, source, length/type). The last pattern byte must arrive before the end-of-data strobe. Bytes that follow the strobe belong to the frame check sequence and are not scanned.

The destination address of the frame is also checked. In strict mode the destination must equal the station address. In relaxed mode any unicast, multicast or broadcast destination is accepted. A detection sets a sticky flag that stays high until it is cleared. A wake output follows the flag only while waking is enabled.

Top module: `magic_wake_det`

## Requirements
- R1: After reset, `magic_seen` and `wake` are both 0.
- R2: A frame sets `magic_seen` when its data field holds 96 consecutive bytes that equal the station address repeated 16 times. The address goes on the wire byte 0 first, and byte 0 is `station_addr[7:0]`. The flag is high from the clock edge that samples the 96th byte of the run.
- R3: Bytes at frame offsets 0 to 13 are never part of a run. A pattern that starts inside the header sets nothing unless a full 96-byte run also lies wholly at offset 14 or later.
- R4: Bytes that arrive after `rx_eod` and before the next start of frame are ignored. A run whose last byte arrives after `rx_eod` sets nothing.
- R5: A run with one bit wrong in any of its 96 bytes does not set the flag.
- R6: After a mismatch, a run can still begin at any later byte, including the byte that broke the earlier run. This also holds when the address has repeated byte values.
- R7: With `any_dest` at 0, a frame counts only if its first six bytes equal the station address in wire order.
- R8: With `any_dest` at 1, a frame counts whatever its destination address, whether unicast, multicast or broadcast.
- R9: `magic_seen` stays high until `flag_clr` is sampled high. The clear takes effect at that edge. If a detection and a clear fall on the same edge, the detection wins.
- R10: `wake` is high exactly when `magic_seen` and `wake_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | A received byte is present on `rx_byte` |
| rx_sof | input | 1 | With `rx_vld`, marks the first byte of a frame |
| rx_eod | input | 1 | Strobe, without a byte, after the last data byte and before the check sequence |
| rx_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station physical address, byte 0 in bits 7:0 |
| any_dest | input | 1 | 0: destination must equal the station address; 1: any destination accepted |
| wake_en | input | 1 | Lets the flag drive `wake` |
| flag_clr | input | 1 | Clears the sticky flag |
| magic_seen | output | 1 | Sticky detection flag |
| wake | output | 1 | Wake request |

## Verification
On every cycle, the assertions check four things. The flag holds until a clear. A clear with no byte present empties it. A rise of the flag always follows a byte accepted inside a frame, and comes no earlier than 110 bytes into the frame. No rise happens between frames. Whether the run detection itself is correct can only be seen from the bench's frames. These include sequences placed at the header boundary and across the end-of-data strobe, single-bit corruptions, restarts after partial runs, addresses with repeated bytes, both destination modes, and random frames scored by a brute-force window search.

// File: rtl/magic_wake_det.sv
module magic_wake_det #(
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16,
  parameter int HDR_BYTES  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_vld,
  input  logic                    rx_sof,
  input  logic                    rx_eod,
  input  logic [7:0]              rx_byte,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    any_dest,
  input  logic                    wake_en,
  input  logic                    flag_clr,
  output logic                    magic_seen,
  output logic                    wake
);
  localparam int RUN   = ADDR_BYTES * COPIES;
  localparam int CW    = $clog2(RUN + 1);
  localparam int PW    = ($clog2(ADDR_BYTES) > 0) ? $clog2(ADDR_BYTES) : 1;
  localparam int HW    = $clog2(HDR_BYTES + 1);
  localparam int NSLOT = 2 ** PW;

  logic [7:0] ab [NSLOT];
  for (genvar g = 0; g < NSLOT; g++) begin : gen_ab
    if (g < ADDR_BYTES) begin : g_real
      assign ab[g] = station_addr[8*g +: 8];
    end else begin : g_pad
      assign ab[g] = '0;
    end
  end

  logic          in_frame, da_eq;
  logic [HW-1:0] pos;
  logic [PW-1:0] ph;
  logic [ADDR_BYTES-1:0] fin;

  wire          take       = rx_vld & (rx_sof | in_frame);
  wire [HW-1:0] idx        = rx_sof ? '0 : pos;
  wire          in_data    = take & (idx == HW'(HDR_BYTES));
  wire          in_da      = take & (idx < HW'(ADDR_BYTES));
  wire          da_byte_ok = rx_byte == ab[idx[PW-1:0]];
  wire          hit        = (|fin) & (any_dest | da_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pos      <= '0;
      ph       <= '0;
      da_eq    <= 1'b0;
    end else begin
      if (rx_vld & rx_sof) in_frame <= 1'b1;
      else if (rx_eod)     in_frame <= 1'b0;
      if (take) begin
        pos <= (idx == HW'(HDR_BYTES)) ? idx : idx + 1'b1;
        if (in_da) da_eq <= ((idx == '0) | da_eq) & da_byte_ok;
        if (rx_sof)       ph <= '0;
        else if (in_data) ph <= (ph == PW'(ADDR_BYTES - 1)) ? '0 : ph + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : gen_slot
    logic [CW-1:0] cnt;
    wire  [PW:0]   sum = {1'b0, ph} + (PW+1)'(ADDR_BYTES - k);
    wire  [PW-1:0] ei  = (sum >= (PW+1)'(ADDR_BYTES)) ? PW'(sum - (PW+1)'(ADDR_BYTES)) : PW'(sum);
    wire           mt  = rx_byte == ab[ei];
    wire           st  = (ph == PW'(k)) & (rx_byte == ab[0]);
    wire           go  = (cnt != '0) & mt;

    assign fin[k] = in_data & go & (cnt == CW'(RUN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (take & rx_sof)  cnt <= '0;
      else if (in_data)        cnt <= go ? ((cnt == CW'(RUN)) ? cnt : cnt + 1'b1)
                                         : (st ? CW'(1) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        magic_seen <= 1'b0;
    else if (hit)      magic_seen <= 1'b1;
    else if (flag_clr) magic_seen <= 1'b0;
  end

  assign wake = magic_seen & wake_en;
endmodule

// File: rtl/magic_wake_det_chk.sv
module magic_wake_det_chk #(
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16,
  parameter int HDR_BYTES  = 14
) (
  input logic clk,
  input logic rst_n,
  input logic rx_vld,
  input logic rx_sof,
  input logic rx_eod,
  input logic flag_clr,
  input logic magic_seen
);
  localparam int LIM = HDR_BYTES + ADDR_BYTES * COPIES;
  localparam int BW  = $clog2(LIM + 1);

  logic          inf;
  logic [BW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inf  <= 1'b0;
      seen <= '0;
    end else begin
      if (rx_vld & rx_sof) inf <= 1'b1;
      else if (rx_eod)     inf <= 1'b0;
      if (rx_vld & rx_sof)                            seen <= BW'(1);
      else if (rx_vld & inf & (seen != BW'(LIM)))     seen <= seen + 1'b1;
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    magic_seen && !flag_clr |=> magic_seen)
    else $error("p_sticky_r9");

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !rx_vld |=> !magic_seen)
    else $error("p_clear_r9");

  p_rise_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(magic_seen) |-> $past(rx_vld && (rx_sof || inf)))
    else $error("p_rise_on_byte_r2");

  p_rise_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(magic_seen) |-> (seen >= BW'(LIM)))
    else $error("p_rise_depth_r3");

  p_idle_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inf && !(rx_vld && rx_sof) && !magic_seen |=> !magic_seen)
    else $error("p_idle_between_r4");
endmodule

bind magic_wake_det magic_wake_det_chk #(
  .ADDR_BYTES(ADDR_BYTES), .COPIES(COPIES), .HDR_BYTES(HDR_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof),
  .rx_eod(rx_eod), .flag_clr(flag_clr), .magic_seen(magic_seen)
);

// File: tb/sim_magic_wake_det.sv
module sim_magic_wake_det;
  localparam int AB  = 6;
  localparam int RUN = 96;
  localparam int HB  = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, rx_vld = 1'b0, rx_sof = 1'b0, rx_eod = 1'b0;
  logic        any_dest = 1'b0, wake_en = 1'b0, flag_clr = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [47:0] station_addr = '0;
  logic        magic_seen, wake;

  magic_wake_det u0 (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eod(rx_eod),
    .rx_byte(rx_byte), .station_addr(station_addr), .any_dest(any_dest),
    .wake_en(wake_en), .flag_clr(flag_clr), .magic_seen(magic_seen), .wake(wake)
  );

  int total = 0, bad = 0;
  bit exp_flag = 1'b0, finished = 1'b0;
  logic [7:0] fr [260];
  int flen = 0, watch = -1, clr_at = -1;

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ab(int i);
    return station_addr[8*(i % AB) +: 8];
  endfunction

  function automatic bit model();
    bit da_ok = any_dest;
    if (!any_dest) begin
      da_ok = 1'b1;
      for (int i = 0; i < AB; i++) if (fr[i] != ab(i)) da_ok = 1'b0;
    end
    for (int s = HB; s + RUN <= flen; s++) begin
      bit ok = 1'b1;
      for (int j = 0; j < RUN; j++) if (fr[s+j] != ab(j)) ok = 1'b0;
      if (ok) return da_ok;
    end
    return 1'b0;
  endfunction

  task automatic fill(int len, bit own_da);
    for (int i = 0; i < 260; i++) fr[i] = 8'($urandom);
    flen = len;
    if (own_da) for (int i = 0; i < AB; i++) fr[i] = ab(i);
  endtask

  task automatic put_seq(int s);
    for (int j = 0; j < RUN; j++) if (s + j < 260) fr[s+j] = ab(j);
  endtask

  task automatic send();
    for (int i = 0; i <= flen; i++) begin
      @(negedge clk);
      if (watch >= 0 && i == watch)     chk("R2 flag low before last run byte", magic_seen, 1'b0);
      if (watch >= 0 && i == watch + 1) chk("R2 flag high right after last run byte", magic_seen, 1'b1);
      flag_clr = (i == clr_at);
      if (i < flen) begin
        rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = fr[i]; rx_eod = 1'b0;
      end else begin
        rx_vld = 1'b0; rx_sof = 1'b0; rx_eod = 1'b1;
      end
    end
    @(negedge clk);
    rx_eod = 1'b0; flag_clr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rx_vld = 1'b1; rx_byte = fr[flen+i];
      @(negedge clk);
    end
    rx_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(string tag);
    bit e = model();
    send();
    exp_flag = exp_flag | e;
    chk(tag, magic_seen, exp_flag);
    chk("R10 wake follows flag and enable", wake, exp_flag & wake_en);
  endtask

  task automatic clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    exp_flag = 1'b0;
    chk("R9 clear empties flag", magic_seen, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int unsigned sd = $urandom(32'd4242);
    sd = sd + 1;
    repeat (3) @(negedge clk);
    chk("R1 flag after reset", magic_seen, 1'b0);
    chk("R1 wake after reset", wake, 1'b0);
    rst_n = 1'b1;
    station_addr = 48'h5a4b3c2d1e0f;
    wake_en = 1'b1;

    fill(140, 1); put_seq(HB); watch = HB + RUN - 1;
    run_frame("R2 run at first data byte");
    watch = -1; clear();

    fill(130, 1); put_seq(8);
    run_frame("R3 run starting in header");

    fill(130, 1); put_seq(130 - 95);
    run_frame("R4 last run byte after end of data");
    fill(130, 1); put_seq(130 - 96);
    run_frame("R4 run ends on last data byte");
    clear();

    fill(160, 1); put_seq(30); fr[80] = fr[80] ^ 8'h10;
    run_frame("R5 single bit error");

    station_addr = 48'h221111111111;
    fill(150, 1); fr[30] = 8'h11; put_seq(31);
    run_frame("R6 restart with repeated address bytes");
    clear();
    station_addr = 48'h5a4b3c2d1e0f;
    fill(160, 1);
    for (int i = 0; i < 4; i++) fr[20+i] = ab(i);
    put_seq(24);
    run_frame("R6 partial run then full run");
    clear();

    fill(150, 1); put_seq(20); fr[5] = fr[5] ^ 8'h01;
    run_frame("R7 destination differs in last byte");
    fill(150, 1); put_seq(20);
    for (int i = 0; i < AB; i++) fr[i] = ab(AB - 1 - i);
    run_frame("R7 destination in reversed byte order");

    any_dest = 1'b1;
    fill(150, 1); put_seq(20);
    for (int i = 0; i < AB; i++) fr[i] = 8'hff;
    run_frame("R8 broadcast destination accepted");
    clear();
    fill(150, 1); put_seq(40); fr[0] = 8'h01; fr[1] = 8'h00; fr[2] = 8'h5e;
    run_frame("R8 multicast destination accepted");
    clear();
    any_dest = 1'b0;

    fill(140, 1); put_seq(HB);
    run_frame("R2 detection before sticky test");
    fill(100, 1);
    run_frame("R9 flag holds across later frame");
    @(negedge clk); wake_en = 1'b0;
    @(negedge clk); chk("R10 wake low when disabled", wake, 1'b0);
    wake_en = 1'b1;
    @(negedge clk); chk("R10 wake high when enabled", wake, 1'b1);
    clear();

    fill(140, 1); put_seq(20); clr_at = 20 + RUN - 1;
    run_frame("R9 detection wins over clear");
    clr_at = -1; clear();

    for (int n = 0; n < 80; n++) begin
      int len, s;
      station_addr = {$urandom, $urandom};
      if ($urandom % 4 == 0) begin
        logic [7:0] a = 8'($urandom);
        station_addr = {a ^ 8'($urandom % 2), a, a, a, a, a};
      end
      any_dest = 1'($urandom);
      wake_en  = 1'($urandom);
      len = HB + ($urandom % 200);
      fill(len, ($urandom % 4) != 0);
      if (fr[0] != ab(0) && $urandom % 2 == 1) for (int i = 0; i < AB; i++) fr[i] = 8'hff;
      if ($urandom % 3 != 0 && len > 8) begin
        s = 8 + ($urandom % (len - 8));
        put_seq(s);
        if ($urandom % 3 == 0) fr[s + ($urandom % RUN) % (260 - s)] ^= 8'(1 << ($urandom % 8));
      end
      run_frame("R2 random frame");
      if ($urandom % 2 == 1) clear();
    end

    summary();
  end
endmodule